// File: doc/BRIEF.md
# Block-Cipher Mode Feedback Unit

This block keeps the 128-bit chaining value that surrounds an external block-cipher core and advances it once for each completed block. Depending on the selected mode, the value stays put (ECB), takes a ciphertext block (CBC and CFB), counts upward in a limited field of its low bits (CTR) or is multiplied by the primitive element of GF(2^128) to produce the next tweak (XTS). Every mode uses one shared register, and its contents are always visible on `fb_o` for the cipher datapath to consume.

Software or a sequencer first writes the starting IV, counter block or encrypted tweak through the load port. After that, each pulse on `blk_done_i` advances the value using the cipher's input and output blocks from the same cycle. A load that lands in the same cycle as a block completion always wins. No cipher rounds are computed here, and no authentication modes are handled.

Top module: `blkmode_fb`

## Requirements
- R1: A synchronous reset (`rst_n` low at a rising edge) clears `fb_o` to zero, even when a load is requested in the same cycle.
- R2: With `load_i` high at a rising edge, `fb_o` shows `load_val_i` after that edge, whatever `blk_done_i` and the mode are.
- R3: When neither `load_i` nor `blk_done_i` is high, `fb_o` holds its value. A done pulse in mode code 0 (ECB) or in an unused mode code (5, 6, 7) also leaves it unchanged.
- R4: In mode code 1 (CBC), a done pulse loads `blk_out_i` when `decrypt_i` is 0 and `blk_in_i` when `decrypt_i` is 1. In both cases that is the ciphertext block.
- R5: In mode code 2 (CFB), a done pulse loads the ciphertext block. For encryption (`decrypt_i` = 0) that is `blk_out_i`; for decryption (`decrypt_i` = 1) it is `blk_in_i`.
- R6: In mode code 3 (CTR), a done pulse adds one modulo 2^m to bits [m-1:0]. The width code `ctr_sel_i` selects m: 0 gives 16, 1 gives 32, 2 gives 64, 3 gives 96, and 4 to 7 give 128.
- R7: In CTR mode, bits [127:m] never change on a done pulse, even when the low field wraps from all ones to zero.
- R8: In mode code 4 (XTS), a done pulse multiplies the value by alpha. The value shifts left by one bit, and when bit 127 was 1 before the shift, bits [7:0] are XORed with 0x87. Byte 0 of the tweak sits at bits [7:0].
- R9: In XTS mode, j successive done pulses after a tweak load T leave T·alpha^j on `fb_o`. There is one multiplication per block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 3 | Mode code: 0 ECB, 1 CBC, 2 CFB, 3 CTR, 4 XTS |
| decrypt_i | input | 1 | 1 selects the decryption direction |
| ctr_sel_i | input | 3 | Counter field width code for CTR |
| load_i | input | 1 | Load strobe for IV, counter block or tweak |
| load_val_i | input | 128 | Value to load |
| blk_done_i | input | 1 | Strobe: the cipher has finished one block |
| blk_in_i | input | 128 | Block presented to the cipher datapath |
| blk_out_i | input | 128 | Block produced by the cipher datapath |
| fb_o | output | 128 | Current feedback, counter or tweak value |

## Verification
Any fault in the feedback register appears on `fb_o` one cycle after the done pulse that caused it, because the register drives the port directly. A mask for the wrong counter width shows up at the field boundary: it either carries into a bit above m or fails to carry below it, so the wrap cases at each width are the telling ones. A bad tweak reduction shows only when bit 127 is set. A missed or doubled update compounds over successive blocks, which is why multi-block CTR and XTS runs are compared against values the bench computes itself.

// File: rtl/blkmode_pkg.sv
// Package: mode codes and counter-width decoding shared by the feedback unit.
// Assumes: callers pass the 3-bit width code unchanged from the port.
package blkmode_pkg;

    typedef enum logic [2:0] {
        FB_ECB = 3'd0,
        FB_CBC = 3'd1,
        FB_CFB = 3'd2,
        FB_CTR = 3'd3,
        FB_XTS = 3'd4
    } fb_mode_e;

    // Turns a width code into the number of counting bits.
    function automatic logic [31:0] ctr_bits(input logic [2:0] sel);
        case (sel)
            3'd0:    ctr_bits = 32'd16;
            3'd1:    ctr_bits = 32'd32;
            3'd2:    ctr_bits = 32'd64;
            3'd3:    ctr_bits = 32'd96;
            default: ctr_bits = 32'd128;
        endcase
    endfunction

endpackage

// File: rtl/blkmode_ctr_step.sv
// Module: computes the next counter block. Only the low m bits count, and they
// wrap modulo 2^m; the bits above stay as they are.
// Assumes: BLK_W is a multiple of GRAN, and every selectable m is a multiple of GRAN.
module blkmode_ctr_step #(
    parameter int BLK_W = 128,
    parameter int GRAN  = 16
) (
    input  logic [BLK_W-1:0] cur_i,
    input  logic [2:0]       width_sel_i,
    output logic [BLK_W-1:0] next_o,
    output logic [BLK_W-1:0] mask_o
);
    import blkmode_pkg::*;

    localparam int NCH = BLK_W / GRAN;

    logic [31:0]      span_bits;
    logic [BLK_W-1:0] plus_one;

    // Decode the field width from the selector.
    always_comb span_bits = ctr_bits(width_sel_i);

    // One mask chunk per granule, set when the granule lies inside the field.
    for (genvar c = 0; c < NCH; c++) begin : g_mask
        assign mask_o[c*GRAN +: GRAN] = (span_bits > 32'(c*GRAN)) ? {GRAN{1'b1}} : {GRAN{1'b0}};
    end

    // Full-width increment; the mask discards any carry beyond the field.
    always_comb plus_one = cur_i + BLK_W'(1);

    // Merge the counted field with the fixed upper bits.
    always_comb next_o = (cur_i & ~mask_o) | (plus_one & mask_o);

endmodule

// File: rtl/blkmode_gf_double.sv
// Module: multiplies a tweak by alpha in GF(2^BLK_W): shifts left by one and
// reduces with POLY into the low byte when the top bit falls out.
// Assumes: byte 0 of the tweak sits at bits [7:0] (little-endian layout).
module blkmode_gf_double #(
    parameter int         BLK_W = 128,
    parameter logic [7:0] POLY  = 8'h87
) (
    input  logic [BLK_W-1:0] cur_i,
    output logic [BLK_W-1:0] next_o
);
    logic             spill;
    logic [BLK_W-1:0] shifted;

    // Separate the outgoing bit from the shifted body.
    always_comb begin
        spill   = cur_i[BLK_W-1];
        shifted = {cur_i[BLK_W-2:0], 1'b0};
    end

    // Fold the reduction polynomial back in when a bit spilled out.
    always_comb next_o = shifted ^ {{(BLK_W-8){1'b0}}, (spill ? POLY : 8'h00)};

endmodule

// File: rtl/blkmode_fb.sv
// Module: feedback register for block-cipher modes. It holds the IV, counter
// or tweak and advances it once for each completed block.
// Assumes: blk_in_i and blk_out_i are valid in the cycle blk_done_i is high;
// a load takes priority over any update in the same cycle.
module blkmode_fb #(
    parameter int         BLK_W = 128,
    parameter int         GRAN  = 16,
    parameter logic [7:0] POLY  = 8'h87
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic             decrypt_i,
    input  logic [2:0]       ctr_sel_i,
    input  logic             load_i,
    input  logic [BLK_W-1:0] load_val_i,
    input  logic             blk_done_i,
    input  logic [BLK_W-1:0] blk_in_i,
    input  logic [BLK_W-1:0] blk_out_i,
    output logic [BLK_W-1:0] fb_o
);
    import blkmode_pkg::*;

    logic [BLK_W-1:0] fb_q;
    logic [BLK_W-1:0] fb_d;
    logic [BLK_W-1:0] ctr_next;
    logic [BLK_W-1:0] ctr_mask;
    logic [BLK_W-1:0] xts_next;
    logic [BLK_W-1:0] cipher_blk;

    blkmode_ctr_step #(.BLK_W(BLK_W), .GRAN(GRAN)) u_ctr (
        .cur_i       (fb_q),
        .width_sel_i (ctr_sel_i),
        .next_o      (ctr_next),
        .mask_o      (ctr_mask)
    );

    blkmode_gf_double #(.BLK_W(BLK_W), .POLY(POLY)) u_gf (
        .cur_i  (fb_q),
        .next_o (xts_next)
    );

    // Pick the ciphertext side: the input block when decrypting, the output otherwise.
    always_comb cipher_blk = decrypt_i ? blk_in_i : blk_out_i;

    // Next-state selection: load first, then the mode update on a done pulse.
    always_comb begin
        fb_d = fb_q;
        if (load_i) begin
            fb_d = load_val_i;
        end else if (blk_done_i) begin
            case (mode_i)
                FB_CBC:  fb_d = cipher_blk;
                FB_CFB:  fb_d = cipher_blk;
                FB_CTR:  fb_d = ctr_next;
                FB_XTS:  fb_d = xts_next;
                default: fb_d = fb_q;
            endcase
        end
    end

    // Feedback register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) fb_q <= '0;
        else        fb_q <= fb_d;
    end

    assign fb_o = fb_q;

    // R2
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (fb_o == $past(load_val_i)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && (!blk_done_i || mode_i == 3'd0 || mode_i > 3'd4)) |=> $stable(fb_o));

    // R4 R5
    cipher_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && blk_done_i && (mode_i == 3'd1 || mode_i == 3'd2))
        |=> (fb_o == (($past(decrypt_i)) ? $past(blk_in_i) : $past(blk_out_i))));

    // R7
    ctr_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && blk_done_i && mode_i == 3'd3)
        |=> ((fb_o & ~$past(ctr_mask)) == ($past(fb_o) & ~$past(ctr_mask))));

    // R8
    xts_feedback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && blk_done_i && mode_i == 3'd4)
        |=> (fb_o[BLK_W-1:8] == $past(fb_o[BLK_W-2:7])));

endmodule

// File: tb/blkmode_fb_test.sv
`timescale 1ns/1ps
module blkmode_fb_test;

    typedef struct packed {
        logic [2:0]   mode;
        logic         dec;
        logic [2:0]   sel;
        logic [127:0] start;
        logic [127:0] din;
        logic [127:0] dout;
        logic [127:0] expv;
        logic [3:0]   req;
    } vec_t;

    localparam logic [127:0] DA = 128'hAAAA5555_0123CDEF_AAAA5555_0F1E2D3C;
    localparam logic [127:0] DB = 128'hBBBB6666_FEDC3210_BBBB6666_F0E1D2C3;
    localparam logic [127:0] S0 = 128'h11112222_33334444_55556666_77778888;
    localparam int NV = 14;

    localparam vec_t VECS [NV] = '{
        // R4 CBC encrypt takes the cipher output
        '{3'd1, 1'b0, 3'd0, S0, DA, DB, DB, 4'd4},
        // R4 CBC decrypt takes the cipher input
        '{3'd1, 1'b1, 3'd0, S0, DA, DB, DA, 4'd4},
        // R5 CFB encrypt
        '{3'd2, 1'b0, 3'd0, S0, DA, DB, DB, 4'd5},
        // R5 CFB decrypt
        '{3'd2, 1'b1, 3'd0, S0, DA, DB, DA, 4'd5},
        // R3 ECB holds
        '{3'd0, 1'b0, 3'd0, S0, DA, DB, S0, 4'd3},
        // R6 R7 16-bit field wraps, bit 16 untouched
        '{3'd3, 1'b0, 3'd0, 128'h12345678_9ABCDEF0_0F0F0F0F_1234FFFF, DA, DB,
                            128'h12345678_9ABCDEF0_0F0F0F0F_12340000, 4'd7},
        // R6 R7 32-bit field wraps
        '{3'd3, 1'b0, 3'd1, 128'hFFFFFFFF_FFFFFFFF_00000001_FFFFFFFF, DA, DB,
                            128'hFFFFFFFF_FFFFFFFF_00000001_00000000, 4'd7},
        // R6 64-bit field carries inside
        '{3'd3, 1'b0, 3'd2, 128'hAAAAAAAA_AAAAAAAA_00000000_FFFFFFFF, DA, DB,
                            128'hAAAAAAAA_AAAAAAAA_00000001_00000000, 4'd6},
        // R6 R7 96-bit field wraps
        '{3'd3, 1'b0, 3'd3, 128'h00000005_FFFFFFFF_FFFFFFFF_FFFFFFFF, DA, DB,
                            128'h00000005_00000000_00000000_00000000, 4'd7},
        // R6 full width wraps
        '{3'd3, 1'b0, 3'd4, {128{1'b1}}, DA, DB, 128'h0, 4'd6},
        // R6 full width plain step (code 7)
        '{3'd3, 1'b1, 3'd7, 128'h1, DA, DB, 128'h2, 4'd6},
        // R8 spill reduces with 0x87
        '{3'd4, 1'b0, 3'd0, 128'h80000000_00000000_00000000_00000001, DA, DB,
                            128'h00000000_00000000_00000000_00000085, 4'd8},
        // R8 no spill
        '{3'd4, 1'b1, 3'd0, 128'h40000000_00000000_00000000_00000003, DA, DB,
                            128'h80000000_00000000_00000000_00000006, 4'd8},
        // R3 unused mode code holds
        '{3'd7, 1'b0, 3'd0, S0, DA, DB, S0, 4'd3}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic [2:0]   mode_i;
    logic         decrypt_i;
    logic [2:0]   ctr_sel_i;
    logic         load_i;
    logic [127:0] load_val_i;
    logic         blk_done_i;
    logic [127:0] blk_in_i;
    logic [127:0] blk_out_i;
    logic [127:0] fb_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    blkmode_fb uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .decrypt_i(decrypt_i),
        .ctr_sel_i(ctr_sel_i), .load_i(load_i), .load_val_i(load_val_i),
        .blk_done_i(blk_done_i), .blk_in_i(blk_in_i), .blk_out_i(blk_out_i),
        .fb_o(fb_o)
    );

    function automatic logic [127:0] times_alpha(input logic [127:0] v);
        logic [127:0] r;
        r = v << 1;
        if (v[127]) r[7:0] = r[7:0] ^ 8'h87;
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load_value(input logic [127:0] v);
        @(negedge clk);
        load_i = 1'b1; load_val_i = v;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic one_block(input logic [2:0] m, input logic d, input logic [2:0] s,
                             input logic [127:0] bi, input logic [127:0] bo);
        mode_i = m; decrypt_i = d; ctr_sel_i = s; blk_in_i = bi; blk_out_i = bo;
        blk_done_i = 1'b1;
        @(negedge clk);
        blk_done_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] model;
        rst_n = 1'b0; mode_i = 3'd0; decrypt_i = 1'b0; ctr_sel_i = 3'd0;
        load_i = 1'b1; load_val_i = DA; blk_done_i = 1'b0; blk_in_i = '0; blk_out_i = '0;
        repeat (3) @(negedge clk);
        // R1 reset beats a concurrent load
        check("R1 reset value", fb_o, 128'h0);
        load_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            load_value(VECS[i].start);
            one_block(VECS[i].mode, VECS[i].dec, VECS[i].sel, VECS[i].din, VECS[i].dout);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), fb_o, VECS[i].expv);
        end

        // R3 no strobe: value held over several cycles
        load_value(S0);
        mode_i = 3'd3; blk_done_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R3 hold without done", fb_o, S0);

        // R2 load overrides a same-cycle CTR update
        @(negedge clk);
        mode_i = 3'd3; ctr_sel_i = 3'd4; blk_done_i = 1'b1;
        load_i = 1'b1; load_val_i = DB;
        @(negedge clk);
        load_i = 1'b0; blk_done_i = 1'b0;
        check("R2 load priority", fb_o, DB);

        // R6 R7 back-to-back steps across the 16-bit wrap
        load_value(128'hCAFE0000_00000000_00000000_0000FFFE);
        one_block(3'd3, 1'b0, 3'd0, DA, DB);
        check("R6 ctr step 1", fb_o, 128'hCAFE0000_00000000_00000000_0000FFFF);
        one_block(3'd3, 1'b0, 3'd0, DA, DB);
        check("R7 ctr step 2 wrap", fb_o, 128'hCAFE0000_00000000_00000000_00000000);

        // R9 consecutive tweaks, one multiplication per block
        model = 128'hC0000000_00000000_00000000_000000F1;
        load_value(model);
        for (int j = 1; j <= 3; j++) begin
            mode_i = 3'd4; blk_done_i = 1'b1;
            @(negedge clk);
            model = times_alpha(model);
            check($sformatf("R9 tweak j=%0d", j), fb_o, model);
        end
        blk_done_i = 1'b0;
        @(negedge clk);
        // R3 tweak held once strobes stop
        check("R3 tweak held", fb_o, model);

        finish_run();
    end

endmodule